// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a clocked register that sits on a memory-module command and address bus. On each rising clock edge it captures the incoming bus and presents it on its outputs. It has two shapes. In the wide shape, 25 input bits pass straight through, one output per input. In the narrow shape, only 14 input bits are captured, and each one drives two output copies. In the narrow shape, a second strap picks whether those 14 bits come from the bottom or the top of the input bus.

Two active-low chip-select inputs gate updates. While both are high, the outputs keep their last value. If either one is low, the register loads normally. An asynchronous active-low reset clears the register at once and overrides the chip-select gating. Reset release passes through a two-stage synchronizer, so the register does not load until the third rising edge after release. Before that edge the outputs stay low, whatever is on the data inputs. The mode straps are treated as static.

Top module: `cmd_reg_buf`

## Requirements
- R1: With `fanout_sel_i` = 0 (wide shape), an enabled capture edge loads `q_o[24:0]` from `d_i[24:0]` and drives `q_o[27:25]` to 0.
- R2: With `fanout_sel_i` = 1 and `map_sel_i` = 0, an enabled capture edge loads both `q_o[13:0]` and `q_o[27:14]` from `d_i[13:0]`.
- R3: With `fanout_sel_i` = 1 and `map_sel_i` = 1, an enabled capture edge loads both `q_o[13:0]` and `q_o[27:14]` from `d_i[24:11]`.
- R4: With `fanout_sel_i` = 0, the value of `map_sel_i` has no effect on `q_o`.
- R5: A capture edge at which `cs_a_ni` and `cs_b_ni` are both 1 leaves `q_o` unchanged.
- R6: A capture edge at which at least one of `cs_a_ni` and `cs_b_ni` is 0 updates `q_o` as given in R1 to R3.
- R7: Driving `rst_ni` low clears `q_o` to 0 at once, with no clock edge needed, even while both chip-selects are 1.
- R8: After `rst_ni` rises, `q_o` stays 0 on the first and second rising edges. The first capture takes place on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fanout_sel_i | input | 1 | Shape strap: 0 selects the 25-bit 1:1 shape, 1 selects the 14-bit 1:2 shape |
| map_sel_i | input | 1 | Narrow-shape source strap: 0 takes the low input bits, 1 takes the high input bits |
| cs_a_ni | input | 1 | First chip-select, active low |
| cs_b_ni | input | 1 | Second chip-select, active low |
| d_i | input | 25 | Command/address input bus |
| q_o | output | 28 | Registered output bus |

## Verification
The bench targets the edges where the gating changes. A held cycle follows an update, and in each shape an update follows a held cycle. A design that treated a single high chip-select as a hold, or that updated on both-high, would show the wrong word there. In the narrow shape the bench drives inputs whose low and high 14-bit slices differ, so a mapping that uses the wrong slice, or fills only one copy, is exposed. The bench also asserts reset mid-cycle with both chip-selects high, and it releases reset with all-ones data. This catches a reset that waits for a clock, that gating blocks, or that loads data before the third edge.

// File: rtl/cmd_buf_pkg.sv
package cmd_buf_pkg;
  typedef enum logic {FAN_1TO1 = 1'b0, FAN_1TO2 = 1'b1} fanout_e;
  typedef enum logic {MAP_LOW  = 1'b0, MAP_HIGH = 1'b1} map_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cmd_rst_sync.sv
module cmd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign run_o = sync_q[STAGES-1];

  // once running, stays running until the next reset (R8)
  assert_run_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> run_o);
endmodule

// File: rtl/cmd_lane_map.sv
module cmd_lane_map
  import cmd_buf_pkg::*;
#(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned NARROW_W = 14,
  parameter int unsigned Q_W      = 28
) (
  input  logic              fanout_i,
  input  logic              map_i,
  input  logic [WIDE_W-1:0] d_i,
  output logic [Q_W-1:0]    q_next_o
);
  localparam int unsigned COPIES = 2;
  localparam int unsigned HI_LSB = WIDE_W - NARROW_W;

  logic [NARROW_W-1:0] narrow_src;
  logic [Q_W-1:0]      narrow_vec;
  logic [Q_W-1:0]      wide_vec;

  assign narrow_src = (map_e'(map_i) == MAP_HIGH) ? d_i[HI_LSB +: NARROW_W]
                                                  : d_i[NARROW_W-1:0];

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    assign narrow_vec[c*NARROW_W +: NARROW_W] = narrow_src;
  end
  if (Q_W > COPIES*NARROW_W) begin : g_narrow_pad
    assign narrow_vec[Q_W-1:COPIES*NARROW_W] = '0;
  end

  always_comb begin
    wide_vec = '0;
    wide_vec[WIDE_W-1:0] = d_i;
  end

  assign q_next_o = (fanout_e'(fanout_i) == FAN_1TO2) ? narrow_vec : wide_vec;
endmodule

// File: rtl/cmd_reg_buf.sv
module cmd_reg_buf
  import cmd_buf_pkg::*;
#(
  parameter  int unsigned WIDE_W      = 25,
  parameter  int unsigned NARROW_W    = 14,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned Q_W         = max_u(WIDE_W, 2*NARROW_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fanout_sel_i,
  input  logic              map_sel_i,
  input  logic              cs_a_ni,
  input  logic              cs_b_ni,
  input  logic [WIDE_W-1:0] d_i,
  output logic [Q_W-1:0]    q_o
);
  logic           run;
  logic           hold;
  logic           upd;
  logic [Q_W-1:0] q_next;

  cmd_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_o (run)
  );

  cmd_lane_map #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .Q_W(Q_W)) i_lane_map (
    .fanout_i(fanout_sel_i),
    .map_i   (map_sel_i),
    .d_i     (d_i),
    .q_next_o(q_next)
  );

  assign hold = cs_a_ni & cs_b_ni;
  assign upd  = run & ~hold;

  // reset wins over chip-select gating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_o <= '0;
    else if (upd) q_o <= q_next;
  end

  assert_wide_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !fanout_sel_i) |=> (q_o[WIDE_W-1:0] == $past(d_i)) &&
                               (q_o[Q_W-1:WIDE_W] == '0));

  assert_copy_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && fanout_sel_i) |=> q_o[NARROW_W-1:0] == q_o[2*NARROW_W-1:NARROW_W]);

  assert_high_map_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && fanout_sel_i && map_sel_i) |=>
      q_o[NARROW_W-1:0] == $past(d_i[WIDE_W-1 -: NARROW_W]));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cs_a_ni && cs_b_ni) |=> $stable(q_o));

  assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> q_o == '0);
endmodule

// File: tb/test_cmd_reg_buf.sv
module test_cmd_reg_buf;
  localparam int unsigned WW = 25;
  localparam int unsigned NW = 14;
  localparam int unsigned QW = 28;
  localparam int unsigned NVEC = 12;

  typedef struct packed {
    logic          fan;
    logic          map;
    logic          csa;
    logic          csb;
    logic [WW-1:0] d;
    logic [3:0]    req;
  } vec_t;

  localparam vec_t [0:NVEC-1] VECS = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 25'h1ABCDEF, 4'd1}, // R1 wide
    '{1'b0, 1'b1, 1'b0, 1'b1, 25'h0F0F0F0, 4'd4}, // R4 map ignored in wide
    '{1'b0, 1'b0, 1'b1, 1'b1, 25'h1555555, 4'd5}, // R5 hold
    '{1'b0, 1'b0, 1'b1, 1'b0, 25'h0AAAAAA, 4'd6}, // R6 one cs low
    '{1'b1, 1'b0, 1'b0, 1'b0, 25'h1FFC123, 4'd2}, // R2 low slice
    '{1'b1, 1'b1, 1'b0, 1'b0, 25'h1FFC123, 4'd3}, // R3 high slice
    '{1'b1, 1'b1, 1'b1, 1'b1, 25'h0000001, 4'd5}, // R5 hold narrow
    '{1'b1, 1'b0, 1'b0, 1'b1, 25'h0003FFF, 4'd6}, // R6 / R2
    '{1'b1, 1'b1, 1'b1, 1'b0, 25'h1FFE000, 4'd6}, // R6 / R3
    '{1'b0, 1'b1, 1'b0, 1'b0, 25'h1FFFFFF, 4'd4}, // R4 / R1 pad zero
    '{1'b0, 1'b0, 1'b1, 1'b1, 25'h0000000, 4'd5}, // R5 hold wide
    '{1'b0, 1'b0, 1'b0, 1'b0, 25'h0000000, 4'd1}  // R1 load zero
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fan = 1'b0, map = 1'b0, csa = 1'b0, csb = 1'b0;
  logic [WW-1:0] d = '0;
  logic [QW-1:0] q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cmd_reg_buf i_cmd_reg_buf (
    .clk_i(clk), .rst_ni(rst_n), .fanout_sel_i(fan), .map_sel_i(map),
    .cs_a_ni(csa), .cs_b_ni(csb), .d_i(d), .q_o(q)
  );

  function automatic logic [QW-1:0] model(logic f, logic m, logic [WW-1:0] x);
    logic [NW-1:0] s;
    if (!f) return {{(QW-WW){1'b0}}, x};
    s = m ? x[WW-1 -: NW] : x[NW-1:0];
    return {s, s};
  endfunction

  task automatic chk(string tag, logic [QW-1:0] act, logic [QW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: q_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [QW-1:0] exp_q;
    repeat (2) @(posedge clk);
    #1 chk("R7 reset state", q, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    exp_q = '0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      fan = VECS[i].fan; map = VECS[i].map;
      csa = VECS[i].csa; csb = VECS[i].csb; d = VECS[i].d;
      @(posedge clk);
      #1;
      if (!(VECS[i].csa && VECS[i].csb))
        exp_q = model(VECS[i].fan, VECS[i].map, VECS[i].d);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), q, exp_q);
    end

    // R7: async clear mid-cycle, both chip-selects high
    @(negedge clk);
    fan = 1'b0; map = 1'b0; csa = 1'b0; csb = 1'b0; d = '1;
    @(posedge clk);
    #1 chk("R1 pre-reset load", q, model(1'b0, 1'b0, '1));
    @(negedge clk) begin csa = 1'b1; csb = 1'b1; end
    #3 rst_n = 1'b0;
    #2 chk("R7 async clear with cs high", q, '0);

    // R8: release with all-ones data, cs enabled
    @(negedge clk) begin csa = 1'b0; csb = 1'b0; rst_n = 1'b1; end
    @(posedge clk);
    #1 chk("R8 edge 1 low", q, '0);
    @(posedge clk);
    #1 chk("R8 edge 2 low", q, '0);
    @(posedge clk);
    #1 chk("R8 edge 3 capture", q, model(1'b0, 1'b0, '1));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule